// File: doc/BRIEF.md
# Lockable Translation Cache with Round-Robin Victim Slot

This block is a fully associative address-translation cache of 8 or 32 slots, filled and maintained by software through a small register port. Each slot pairs a tag word (virtual page tag, page-size code, preserve bit, valid bit) with a data word (physical page base plus endianness, element-size and mixed-access attribute bits). Software stages a tag word and a data word, then issues a commit. The commit writes both words into the slot selected by a software-owned victim index.

A lock register sets a floor index. Slots below the floor are protected from commits and from the global invalidate. Replacement is a plain round-robin that software drives: it advances the victim index and wraps it back to the floor itself, and the block never moves the index on its own. Software can also select a slot with the victim index and read that slot back. It can invalidate every slot whose page covers a given address, or invalidate every unprotected slot.

A combinational lookup port translates a virtual address in the same cycle it is presented. There is no back-pressure on this port: the lookup is always accepted, and hit or miss is reported for each cycle that the request is valid. Walking page tables on a miss is left to the agent outside the block, which sees only the miss flag.

Top module: `lk_tlb`

## Requirements
- R1: After reset every slot is invalid, the lock register reads 0, every slot reads back as zero, and a valid lookup misses.
- R2: Register select codes are 0 lock, 1 staged tag, 2 staged data, 3 commit, 4 invalidate-by-address, 5 invalidate-all, 6 read back the tag of the slot at the victim index, 7 read back the data of that slot. The lock word carries the floor in bits 14:10 and the victim index in bits 8:4. Only the low log2(ENTRIES) bits of each field are kept, and all other lock bits read as 0.
- R3: A commit writes the staged tag and data words into the slot at the victim index when that index is not below the floor. The tag word holds the virtual tag in bits 31:12, the valid flag in bit 2 and the page-size code in bits 1:0.
- R4: A commit whose victim index is below the floor changes no slot.
- R5: Read-back codes 6 and 7 return the stored tag and data words of the slot at the victim index, with that slot's current valid bit.
- R6: A lookup hits when a valid slot's tag equals the lookup address over that slot's page. Page-size codes are 0 = 16 MB, 1 = 1 MB, 2 = 64 KB and 3 = 4 KB. The physical address is the stored base above the page boundary joined with the lookup address below it.
- R7: When several valid slots match, the lowest-indexed slot supplies the translation.
- R8: While a lookup is valid, exactly one of hit and miss is high. While no lookup is valid, both are low.
- R9: Invalidate-by-address clears the valid bit of every slot whose page range contains bits 31:12 of the staged tag word, for all four page sizes. Protected slots are included, and other slots are left unchanged.
- R10: Invalidate-all clears every slot at or above the floor and leaves slots below it intact. With a floor of 0 it clears every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Register read data (combinational) |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_va | input | 32 | Lookup virtual address |
| lkp_hit | output | 1 | Lookup hit |
| lkp_miss | output | 1 | Lookup miss |
| lkp_pa | output | 32 | Translated physical address, meaningful on hit |

## Verification
A wrong valid bit or a corrupted tag shows up at the lookup port in the first cycle after the register write that caused it. It appears either as a missing hit or as a stale translation. A commit or a global invalidate that reaches past the lock floor changes the result of the very next lookup of a protected page. It also changes the tag word read back for that slot. The directed scenarios are therefore arranged so that each command is followed immediately by a lookup and a read-back of the slots it could have touched.

// File: rtl/lk_tlb_pkg.sv
package lk_tlb_pkg;

  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 5;
  localparam int FLOOR_LSB  = 10;
  localparam int VICT_LSB   = 4;
  localparam int TAG_VLD_BIT = 2;

  typedef enum logic [2:0] {
    SEL_LOCK      = 3'd0,
    SEL_TAG       = 3'd1,
    SEL_DATA      = 3'd2,
    SEL_COMMIT    = 3'd3,
    SEL_INV_ADDR  = 3'd4,
    SEL_INV_ALL   = 3'd5,
    SEL_PEEK_TAG  = 3'd6,
    SEL_PEEK_DATA = 3'd7
  } reg_sel_e;

  // Address bits that belong to the page number for a given size code.
  function automatic logic [WORD_W-1:0] page_mask(input logic [1:0] code);
    case (code)
      2'd0:    page_mask = 32'hFF00_0000;
      2'd1:    page_mask = 32'hFFF0_0000;
      2'd2:    page_mask = 32'hFFFF_0000;
      default: page_mask = 32'hFFFF_F000;
    endcase
  endfunction

endpackage

// File: rtl/lk_tlb_slot.sv
module lk_tlb_slot
  import lk_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_commit,
  input  logic              do_inv_all,
  input  logic              do_inv_addr,
  input  logic [WORD_W-1:0] tag_d,
  input  logic [WORD_W-1:0] data_d,
  input  logic [WORD_W-1:0] lkp_va,
  input  logic [WORD_W-1:0] inv_va,
  output logic [WORD_W-1:0] tag_q,
  output logic [WORD_W-1:0] data_q,
  output logic              vld,
  output logic              lkp_match
);

  logic [WORD_W-1:0] mask;
  logic              inv_match;

  assign vld       = tag_q[TAG_VLD_BIT];
  assign mask      = page_mask(tag_q[1:0]);
  assign lkp_match = vld && (((lkp_va ^ tag_q) & mask) == '0);
  assign inv_match = vld && (((inv_va ^ tag_q) & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      data_q <= '0;
    end else if (do_commit) begin
      tag_q  <= tag_d;
      data_q <= data_d;
    end else if (do_inv_all || (do_inv_addr && inv_match)) begin
      tag_q[TAG_VLD_BIT] <= 1'b0;
    end
  end

endmodule

// File: rtl/lk_tlb_pick.sv
module lk_tlb_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/lk_tlb.sv
module lk_tlb
  import lk_tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        lkp_valid,
  input  logic [31:0] lkp_va,
  output logic        lkp_hit,
  output logic        lkp_miss,
  output logic [31:0] lkp_pa
);

  localparam int IW = $clog2(ENTRIES);

  logic [IW-1:0]     floor_q, vict_q;
  logic [WORD_W-1:0] tag_stage, data_stage;
  logic [WORD_W-1:0] tag_arr  [ENTRIES];
  logic [WORD_W-1:0] data_arr [ENTRIES];
  logic [ENTRIES-1:0] vld_vec, match_vec;
  logic              commit_ok, inv_all_cmd, inv_addr_cmd;
  logic              any_match;
  logic [IW-1:0]     win_idx;
  logic [WORD_W-1:0] win_mask;
  logic [WORD_W-1:0] lock_word;

  // Lock and staging registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      floor_q    <= '0;
      vict_q     <= '0;
      tag_stage  <= '0;
      data_stage <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_LOCK: begin
          floor_q <= wr_data[FLOOR_LSB +: IW];
          vict_q  <= wr_data[VICT_LSB +: IW];
        end
        SEL_TAG:  tag_stage  <= wr_data;
        SEL_DATA: data_stage <= wr_data;
        default: ;
      endcase
    end
  end

  assign commit_ok    = wr_en && (wr_sel == SEL_COMMIT) && (vict_q >= floor_q);
  assign inv_all_cmd  = wr_en && (wr_sel == SEL_INV_ALL);
  assign inv_addr_cmd = wr_en && (wr_sel == SEL_INV_ADDR);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    localparam logic [IW-1:0] SLOT = IW'(g);
    lk_tlb_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .do_commit  (commit_ok && (vict_q == SLOT)),
      .do_inv_all (inv_all_cmd && (SLOT >= floor_q)),
      .do_inv_addr(inv_addr_cmd),
      .tag_d      (tag_stage),
      .data_d     (data_stage),
      .lkp_va     (lkp_va),
      .inv_va     (tag_stage),
      .tag_q      (tag_arr[g]),
      .data_q     (data_arr[g]),
      .vld        (vld_vec[g]),
      .lkp_match  (match_vec[g])
    );
  end

  lk_tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick (
    .req(match_vec),
    .any(any_match),
    .idx(win_idx)
  );

  assign win_mask = page_mask(tag_arr[win_idx][1:0]);
  assign lkp_hit  = lkp_valid && any_match;
  assign lkp_miss = lkp_valid && !any_match;
  assign lkp_pa   = (data_arr[win_idx] & win_mask) | (lkp_va & ~win_mask);

  always_comb begin
    lock_word = '0;
    lock_word[FLOOR_LSB +: IW] = floor_q;
    lock_word[VICT_LSB +: IW]  = vict_q;
  end

  always_comb begin
    case (rd_sel)
      SEL_LOCK:      rd_data = lock_word;
      SEL_TAG:       rd_data = tag_stage;
      SEL_DATA:      rd_data = data_stage;
      SEL_PEEK_TAG:  rd_data = tag_arr[vict_q];
      SEL_PEEK_DATA: rd_data = data_arr[vict_q];
      default:       rd_data = '0;
    endcase
  end

endmodule

// File: rtl/lk_tlb_chk.sv
module lk_tlb_chk #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic [IW-1:0] floor_q,
  input logic [IW-1:0] vict_q,
  input logic [N-1:0]  vld_vec,
  input logic          lkp_valid,
  input logic          lkp_hit,
  input logic          lkp_miss
);

  logic [N-1:0] low_mask;

  always_comb begin
    for (int i = 0; i < N; i++) low_mask[i] = (IW'(i) < floor_q);
  end

  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |-> (lkp_hit != lkp_miss));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> (!lkp_hit && !lkp_miss));

  // R4
  locked_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3 && vict_q < floor_q) |=> (vld_vec == $past(vld_vec)));

  // R10
  floor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd5) |=> ((vld_vec & low_mask) == $past(vld_vec & low_mask)));

  // R10
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd5 && floor_q == '0) |=> (vld_vec == '0));

  // R6
  hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> (vld_vec != '0));

endmodule

bind lk_tlb lk_tlb_chk #(.N(ENTRIES), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .floor_q  (floor_q),
  .vict_q   (vict_q),
  .vld_vec  (vld_vec),
  .lkp_valid(lkp_valid),
  .lkp_hit  (lkp_hit),
  .lkp_miss (lkp_miss)
);

// File: tb/test_lk_tlb.sv
module test_lk_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_va = '0;
  logic        lkp_hit, lkp_miss;
  logic [31:0] lkp_pa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lk_tlb i_lk_tlb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lkp_valid(lkp_valid), .lkp_va(lkp_va),
    .lkp_hit(lkp_hit), .lkp_miss(lkp_miss), .lkp_pa(lkp_pa)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic lock(input int floor_v, input int vict_v);
    wr(3'd0, (32'(floor_v) << 10) | (32'(vict_v) << 4));
  endtask

  task automatic install(input int slot, input logic [31:0] tag, input logic [31:0] data);
    lock(0, slot);
    wr(3'd1, tag);
    wr(3'd2, data);
    wr(3'd3, 32'h0);
  endtask

  // expect_pa valid only when exp_hit is 1
  task automatic look(input string req, input logic [31:0] va, input bit exp_hit,
                      input logic [31:0] exp_pa);
    lkp_valid = 1'b1; lkp_va = va;
    #1;
    check(req, {30'b0, lkp_hit, lkp_miss}, {30'b0, exp_hit, !exp_hit});
    if (exp_hit) check(req, lkp_pa, exp_pa);
    lkp_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd0, v); check("R1 lock", v, 32'h0);
    rd(3'd6, v); check("R1 tag slot0", v, 32'h0);
    rd(3'd7, v); check("R1 data slot0", v, 32'h0);
    look("R1 lookup", 32'h1234_5678, 1'b0, 32'h0);
  endtask

  task automatic t_lock_fields;
    logic [31:0] v;
    wr(3'd0, 32'h0000_7DF0);
    rd(3'd0, v); check("R2 lock fields", v, 32'h0000_7DF0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R2 lock other bits", v, 32'h0000_7DF0);
    wr(3'd0, 32'h0);
    rd(3'd0, v); check("R2 lock clear", v, 32'h0);
  endtask

  task automatic t_sizes;
    logic [31:0] v;
    install(0, 32'h1234_5007, 32'h8765_4000);
    rd(3'd6, v); check("R5 tag readback", v, 32'h1234_5007);
    rd(3'd7, v); check("R5 data readback", v, 32'h8765_4000);
    look("R3 R6 4K", 32'h1234_5ABC, 1'b1, 32'h8765_4ABC);
    install(1, 32'h0500_0004, 32'h2200_0000);
    look("R6 16M", 32'h05AB_CDEF, 1'b1, 32'h22AB_CDEF);
    install(2, 32'h7010_0005, 32'h4030_0000);
    look("R6 1M", 32'h701F_FFFF, 1'b1, 32'h403F_FFFF);
    install(3, 32'h9ABC_0006, 32'h1111_0000);
    look("R6 64K", 32'h9ABC_F123, 1'b1, 32'h1111_F123);
    look("R8 miss", 32'h0000_0000, 1'b0, 32'h0);
    lkp_va = 32'h1234_5ABC;
    #1;
    check("R8 idle", {30'b0, lkp_hit, lkp_miss}, 32'h0);
  endtask

  task automatic t_priority;
    install(5, 32'h1200_0004, 32'h3300_0000);
    look("R7 lowest wins", 32'h1234_5ABC, 1'b1, 32'h8765_4ABC);
    look("R7 wide only", 32'h1299_0000, 1'b1, 32'h3399_0000);
  endtask

  task automatic t_inv_addr;
    logic [31:0] v;
    wr(3'd1, 32'h7018_0000);
    wr(3'd4, 32'h0);
    look("R9 1M cleared", 32'h7010_0000, 1'b0, 32'h0);
    look("R9 others kept", 32'h9ABC_0000, 1'b1, 32'h1111_0000);
    wr(3'd1, 32'h1234_5000);
    wr(3'd4, 32'h0);
    look("R9 both covering cleared", 32'h1234_5ABC, 1'b0, 32'h0);
    lock(0, 5);
    rd(3'd6, v); check("R5 R9 slot5 invalid", v, 32'h1200_0000);
  endtask

  task automatic t_lock_protect;
    logic [31:0] v;
    lock(2, 1);
    wr(3'd1, 32'hCCCC_C007);
    wr(3'd2, 32'hDDDD_D000);
    wr(3'd3, 32'h0);
    look("R4 locked commit ignored", 32'hCCCC_C000, 1'b0, 32'h0);
    rd(3'd6, v); check("R4 slot1 tag kept", v, 32'h0500_0004);
    rd(3'd7, v); check("R4 slot1 data kept", v, 32'h2200_0000);
    wr(3'd5, 32'h0);
    look("R10 protected kept", 32'h0500_0000, 1'b1, 32'h2200_0000);
    look("R10 unprotected cleared", 32'h9ABC_0000, 1'b0, 32'h0);
    lock(0, 0);
    wr(3'd5, 32'h0);
    look("R10 full clear", 32'h0500_0000, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_fields();
    t_sizes();
    t_priority();
    t_inv_addr();
    t_lock_protect();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule